// File: doc/BRIEF.md
# Event Notification Trigger Generator

This block is the interrupt front end of a host bridge. Interrupt sources report their state as assertion and deassertion events. The block keeps the current state of every source in a level register. Each accepted assertion also makes that source owe one notification to the interrupt controller.

A notification is a single posted 64-bit memory write. It goes to a programmed notification address. Its data word combines a trigger flag, a software-programmed offset and the source number. The word is presented big-endian on a request/acknowledge port. Only one write is outstanding at a time. Notifications that fall due while a write is in flight wait in a per-source pending bitmap. They are sent lowest source first once the acknowledge returns.

Software programs the block through byte-addressed 64-bit register writes and reads. One register holds the notification address and its enable. Another holds the offset. A control register selects the interrupt method and can clear all source state. A base register for the event pages signals map and unmap requests when its valid flag toggles.

Top module: `evtg_top`

## Requirements
- R1: After reset, registers 0x58, 0x60, 0x68 and 0x70 read zero, `level_o` is zero, and `mem_req_o`, `notify_err_o`, `page_map_o` and `page_unmap_o` are low.
- R2: Reads combinationally return the stored value of 0x58, 0x60, 0x68 and 0x70. Reads of 0x20 and 0x28 return zero. Every other offset reads all ones. Writes to 0x20, 0x28 or any unlisted offset change no state.
- R3: An accepted event for source n (n < NSRC) sets bit 63-n of `level_o` on assertion and clears it on deassertion. The change is visible one cycle after the event.
- R4: A notification for source n writes to address (reg 0x68 with bit 0 cleared). Its data word is TRIG (default 0x8000_0000) ORed with (reg 0x70 >> 32) and n. The word is byte-swapped onto `mem_data_o`, so its bits 63:56 appear on `mem_data_o[7:0]`.
- R5: Bit 0 of reg 0x68 is the notification enable. While it is clear, no request is raised. Notifications that come due then are discarded and are not sent after the enable is set again.
- R6: `mem_req_o` stays high with stable address and data until `mem_ack_i`. Each notification produces exactly one write. An acknowledge with `mem_err_i` high pulses `notify_err_o` for one cycle in the cycle after the acknowledge, and the write is not retried.
- R7: Assertions that arrive while a write is outstanding are held per source. After the acknowledge they are issued in ascending source order.
- R8: While bit 63 of reg 0x58 is set, all source events are ignored: the level register is unchanged and no notification is raised.
- R9: A write to reg 0x58 with bit 62 set clears the level register and all pending notifications within two cycles. A write already in flight completes normally.
- R10: A write to reg 0x60 pulses `page_map_o` when bit 0 goes from 0 to 1 and `page_unmap_o` when it goes from 1 to 0. Each pulse lasts one cycle, in the cycle after the write. `page_base_o` is reg 0x60 with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| evt_vld_i | input | 1 | Source event strobe |
| evt_id_i | input | ID_W | Source number |
| evt_lvl_i | input | 1 | 1 = assertion, 0 = deassertion |
| level_o | output | 64 | Level register, source n at bit 63-n |
| mem_req_o | output | 1 | Notification write request |
| mem_addr_o | output | 64 | Notification write address |
| mem_data_o | output | 64 | Notification data, big-endian byte order |
| mem_ack_i | input | 1 | Write acknowledge |
| mem_err_i | input | 1 | Write failed, qualified by mem_ack_i |
| notify_err_o | output | 1 | One-cycle pulse on a failed write |
| page_map_o | output | 1 | Map pulse for the event pages |
| page_unmap_o | output | 1 | Unmap pulse for the event pages |
| page_base_o | output | 64 | Event-page base address |

## Verification
The assertions assume that `mem_ack_i` and `mem_err_i` rise only while `mem_req_o` is high, and that `mem_err_i` has meaning only together with `mem_ack_i`. The stimulus drives the acknowledge only after it has seen the request high, and it drops both signals on the next cycle.

Events and register writes are applied one at a time on the falling edge. No event coincides with a control-register write, so the check that the LSI mode holds the level register steady never sees a reset pulse in the same cycle.

The bench sweeps every source through the full assertion, notification and deassertion cycle. It also covers queued ordering, the error, disabled, LSI and clear paths, and all valid-flag transitions of the page base.

// File: rtl/evtg_pkg.sv
package evtg_pkg;
  localparam logic [7:0] OFS_CR    = 8'h20;
  localparam logic [7:0] OFS_SEMR  = 8'h28;
  localparam logic [7:0] OFS_ICTL  = 8'h58;
  localparam logic [7:0] OFS_PAGE  = 8'h60;
  localparam logic [7:0] OFS_NADDR = 8'h68;
  localparam logic [7:0] OFS_IVOFS = 8'h70;

  localparam int unsigned ICTL_LSI_BIT = 63;
  localparam int unsigned ICTL_RST_BIT = 62;

  function automatic logic [63:0] bswap64(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/evtg_regs.sv
module evtg_regs
  import evtg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] rdata_o,
  output logic [63:0] ictl_o,
  output logic [63:0] page_o,
  output logic [63:0] naddr_o,
  output logic [63:0] ivofs_o,
  output logic        src_rst_o,
  output logic        map_o,
  output logic        unmap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ictl_o    <= '0;
      page_o    <= '0;
      naddr_o   <= '0;
      ivofs_o   <= '0;
      src_rst_o <= 1'b0;
      map_o     <= 1'b0;
      unmap_o   <= 1'b0;
    end else begin
      src_rst_o <= 1'b0;
      map_o     <= 1'b0;
      unmap_o   <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          OFS_ICTL: begin
            ictl_o    <= wdata_i;
            src_rst_o <= wdata_i[ICTL_RST_BIT];
          end
          OFS_PAGE: begin
            page_o  <= wdata_i;
            map_o   <= wdata_i[0] & ~page_o[0];
            unmap_o <= ~wdata_i[0] & page_o[0];
          end
          OFS_NADDR: naddr_o <= wdata_i;
          OFS_IVOFS: ivofs_o <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CR, OFS_SEMR: rdata_o = '0;
      OFS_ICTL:         rdata_o = ictl_o;
      OFS_PAGE:         rdata_o = page_o;
      OFS_NADDR:        rdata_o = naddr_o;
      OFS_IVOFS:        rdata_o = ivofs_o;
      default:          rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/evtg_srcs.sv
module evtg_srcs #(
  parameter int unsigned NSRC = 20,
  localparam int unsigned ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_vld_i,
  input  logic [ID_W-1:0] evt_id_i,
  input  logic            evt_lvl_i,
  input  logic            lsi_i,
  input  logic            src_rst_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [63:0]     level_o,
  output logic [NSRC-1:0] pend_o
);
  logic            acc;
  logic [NSRC-1:0] hit, lvl_q, lvl_d, pend_d;

  assign acc = evt_vld_i & ~lsi_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g]    = acc && (evt_id_i == ID_W'(g));
    assign lvl_d[g]  = hit[g] ? evt_lvl_i : lvl_q[g];
    // a fresh assertion wins over a same-cycle issue clear
    assign pend_d[g] = (pend_o[g] & ~clr_i[g]) | (hit[g] & evt_lvl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_o <= '0;
    end else if (src_rst_i) begin
      lvl_q  <= '0;
      pend_o <= '0;
    end else begin
      lvl_q  <= lvl_d;
      pend_o <= pend_d;
    end
  end

  always_comb begin
    level_o = '0;
    for (int i = 0; i < NSRC; i++) level_o[63-i] = lvl_q[i];
  end
endmodule

// File: rtl/evtg_notify.sv
module evtg_notify
  import evtg_pkg::*;
#(
  parameter int unsigned NSRC = 20,
  parameter logic [63:0] TRIG = 64'h8000_0000,
  localparam int unsigned ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic [63:0]     naddr_i,
  input  logic [31:0]     ivofs_hi_i,
  input  logic            mem_ack_i,
  input  logic            mem_err_i,
  output logic [NSRC-1:0] clr_o,
  output logic            mem_req_o,
  output logic [63:0]     mem_addr_o,
  output logic [63:0]     mem_data_o,
  output logic            err_o
);
  logic            busy_q, sel_vld, issue;
  logic [ID_W-1:0] sel;
  logic [63:0]     word;

  always_comb begin
    sel_vld = 1'b0;
    sel     = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        sel_vld = 1'b1;
        sel     = ID_W'(i);
      end
    end
  end

  assign issue = ~busy_q & naddr_i[0] & sel_vld;
  assign word  = TRIG | {32'b0, ivofs_hi_i} | 64'(sel);

  always_comb begin
    clr_o = '0;
    if (!busy_q) begin
      if (naddr_i[0]) begin
        if (sel_vld) clr_o[sel] = 1'b1;
      end else begin
        clr_o = pend_i;  // disabled: drop everything due
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      err_o      <= 1'b0;
    end else begin
      err_o <= busy_q & mem_ack_i & mem_err_i;
      if (issue) begin
        busy_q     <= 1'b1;
        mem_addr_o <= {naddr_i[63:1], 1'b0};
        mem_data_o <= bswap64(word);
      end else if (busy_q && mem_ack_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign mem_req_o = busy_q;
endmodule

// File: rtl/evtg_top.sv
module evtg_top
  import evtg_pkg::*;
#(
  parameter int unsigned NSRC = 20,
  parameter logic [63:0] TRIG = 64'h8000_0000,
  localparam int unsigned ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [7:0]      reg_addr_i,
  input  logic [63:0]     reg_wdata_i,
  output logic [63:0]     reg_rdata_o,
  input  logic            evt_vld_i,
  input  logic [ID_W-1:0] evt_id_i,
  input  logic            evt_lvl_i,
  output logic [63:0]     level_o,
  output logic            mem_req_o,
  output logic [63:0]     mem_addr_o,
  output logic [63:0]     mem_data_o,
  input  logic            mem_ack_i,
  input  logic            mem_err_i,
  output logic            notify_err_o,
  output logic            page_map_o,
  output logic            page_unmap_o,
  output logic [63:0]     page_base_o
);
  logic [63:0]     ictl_q, page_q, naddr_q, ivofs_q;
  logic            src_rst;
  logic [NSRC-1:0] pend, clr;

  evtg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ictl_o(ictl_q), .page_o(page_q), .naddr_o(naddr_q), .ivofs_o(ivofs_q),
    .src_rst_o(src_rst), .map_o(page_map_o), .unmap_o(page_unmap_o)
  );

  evtg_srcs #(.NSRC(NSRC)) u_srcs (
    .clk_i, .rst_ni,
    .evt_vld_i, .evt_id_i, .evt_lvl_i,
    .lsi_i(ictl_q[ICTL_LSI_BIT]), .src_rst_i(src_rst), .clr_i(clr),
    .level_o, .pend_o(pend)
  );

  evtg_notify #(.NSRC(NSRC), .TRIG(TRIG)) u_notify (
    .clk_i, .rst_ni,
    .pend_i(pend), .naddr_i(naddr_q), .ivofs_hi_i(ivofs_q[63:32]),
    .mem_ack_i, .mem_err_i,
    .clr_o(clr), .mem_req_o, .mem_addr_o, .mem_data_o, .err_o(notify_err_o)
  );

  assign page_base_o = {page_q[63:1], 1'b0};
endmodule

// File: rtl/evtg_chk.sv
module evtg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        evt_vld_i,
  input logic [63:0] level_o,
  input logic        mem_req_o,
  input logic [63:0] mem_addr_o,
  input logic [63:0] mem_data_o,
  input logic        mem_ack_i,
  input logic        mem_err_i,
  input logic        notify_err_o,
  input logic        page_map_o,
  input logic        page_unmap_o,
  input logic [63:0] naddr_q,
  input logic [63:0] ictl_q
);
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  p_err_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(notify_err_o) |-> $past(mem_req_o && mem_ack_i && mem_err_i));

  p_req_needs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(naddr_q[0]));

  p_addr_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);

  p_lsi_ignores_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ictl_q[63] && evt_vld_i && !reg_we_i) |=> $stable(level_o));

  p_map_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(page_map_o && page_unmap_o));
endmodule

bind evtg_top evtg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .evt_vld_i(evt_vld_i),
  .level_o(level_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_data_o(mem_data_o), .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
  .notify_err_o(notify_err_o), .page_map_o(page_map_o),
  .page_unmap_o(page_unmap_o), .naddr_q(naddr_q), .ictl_q(ictl_q)
);

// File: tb/tb_evtg_top.sv
`timescale 1ns/1ps
module tb_evtg_top;
  localparam int NSRC = 20;
  localparam int ID_W = $clog2(NSRC);
  localparam logic [63:0] NADDR = 64'h0000_0000_0001_2345;
  localparam logic [63:0] IVOFS = 64'h0000_0100_dead_beef;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [7:0] reg_addr = 0; logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata, level, mem_addr, mem_data, page_base;
  logic evt_vld = 0, evt_lvl = 0; logic [ID_W-1:0] evt_id = 0;
  logic mem_req, mem_ack = 0, mem_err = 0, nerr, pmap, punmap;
  int n_chk = 0, n_fail = 0, map_cnt = 0, unmap_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evtg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .evt_vld_i(evt_vld),
    .evt_id_i(evt_id), .evt_lvl_i(evt_lvl), .level_o(level),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .notify_err_o(nerr),
    .page_map_o(pmap), .page_unmap_o(punmap), .page_base_o(page_base)
  );

  always @(posedge clk) begin
    if (pmap) map_cnt++;
    if (punmap) unmap_cnt++;
  end

  function automatic logic [63:0] swap(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] exp_data(input int n);
    return swap(64'h8000_0000 | (IVOFS >> 32) | 64'(n));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [63:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic evt(input int id, input bit l);
    @(negedge clk); evt_vld = 1; evt_id = ID_W'(id); evt_lvl = l;
    @(negedge clk); evt_vld = 0;
  endtask

  task automatic wait_req(input string req);
    for (int i = 0; i < 20; i++) begin
      if (mem_req) break;
      @(negedge clk);
    end
    chk(req, 64'(mem_req), 64'd1);
  endtask

  task automatic ack(input bit e);
    mem_ack = 1; mem_err = e;
    @(negedge clk); mem_ack = 0; mem_err = 0;
    chk("R6 error pulse", 64'(nerr), 64'(e));
  endtask

  task automatic no_req(input string req, input int cyc);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (mem_req) seen = 1;
    end
    chk(req, 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 ictl", 8'h58, 64'h0);
    rd("R1 page", 8'h60, 64'h0);
    rd("R1 naddr", 8'h68, 64'h0);
    rd("R1 ivofs", 8'h70, 64'h0);
    chk("R1 level", level, 64'h0);
    chk("R1 req", 64'(mem_req), 64'd0);
    // R2 read map and ignored writes
    wr(8'h20, 64'h1234); wr(8'h28, 64'h5678); wr(8'h78, 64'h9);
    rd("R2 cr ignored", 8'h20, 64'h0);
    rd("R2 semr ignored", 8'h28, 64'h0);
    rd("R2 level reads ones", 8'h78, '1);
    rd("R2 unknown reads ones", 8'h00, '1);
    wr(8'h70, IVOFS); wr(8'h68, NADDR);
    rd("R2 naddr stored", 8'h68, NADDR);
    rd("R2 ivofs stored", 8'h70, IVOFS);
    // R3 R4 sweep every source
    for (int n = 0; n < NSRC; n++) begin
      evt(n, 1);
      chk("R3 level set", level, 64'h1 << (63 - n));
      wait_req("R4 request");
      chk("R4 addr", mem_addr, NADDR & ~64'h1);
      chk("R4 data", mem_data, exp_data(n));
      ack(0);
      evt(n, 0);
      chk("R3 level clear", level, 64'h0);
    end
    // R7 queued ordering
    evt(7, 1);
    wait_req("R7 first");
    chk("R7 first data", mem_data, exp_data(7));
    evt(11, 1); evt(3, 1); evt(1, 1);
    chk("R6 held", 64'(mem_req), 64'd1);
    ack(0);
    wait_req("R7 q0"); chk("R7 order 1", mem_data, exp_data(1)); ack(0);
    wait_req("R7 q1"); chk("R7 order 3", mem_data, exp_data(3)); ack(0);
    wait_req("R7 q2"); chk("R7 order 11", mem_data, exp_data(11)); ack(0);
    no_req("R6 one write each", 5);
    // R9 clear source state, including a pending one
    evt(5, 1);
    wait_req("R9 inflight");
    evt(6, 1);
    wr(8'h58, 64'h4000_0000_0000_0000);
    @(negedge clk);
    chk("R9 level cleared", level, 64'h0);
    rd("R2 ictl stored", 8'h58, 64'h4000_0000_0000_0000);
    chk("R9 inflight kept", mem_data, exp_data(5));
    ack(0);
    no_req("R9 pending dropped", 6);
    wr(8'h58, 64'h0);
    // R6 error, no retry
    evt(9, 1);
    wait_req("R6 err req");
    ack(1);
    no_req("R6 no retry", 6);
    evt(9, 0);
    // R8 LSI method rejects events
    wr(8'h58, 64'h8000_0000_0000_0000);
    evt(4, 1);
    chk("R8 level unchanged", level, 64'h0);
    no_req("R8 no notify", 6);
    wr(8'h58, 64'h0);
    // R5 disabled notifications are discarded
    wr(8'h68, NADDR & ~64'h1);
    evt(2, 1);
    chk("R5 level still tracked", level, 64'h1 << 61);
    no_req("R5 no write", 6);
    wr(8'h68, NADDR);
    no_req("R5 dropped", 6);
    evt(2, 0);
    // R10 page map/unmap
    wr(8'h60, 64'h0000_0000_4000_1001);
    @(negedge clk);
    chk("R10 map", 64'(map_cnt), 64'd1);
    chk("R10 base", page_base, 64'h0000_0000_4000_1000);
    wr(8'h60, 64'h0000_0000_4000_2001);
    @(negedge clk);
    chk("R10 no remap", 64'(map_cnt), 64'd1);
    wr(8'h60, 64'h0000_0000_4000_2000);
    @(negedge clk);
    chk("R10 unmap", 64'(unmap_cnt), 64'd1);
    chk("R10 map count", 64'(map_cnt), 64'd1);
    rd("R2 page stored", 8'h60, 64'h0000_0000_4000_2000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule